// File: doc/BRIEF.md
# Boundary-Scan Serial Shift Engine

This block is the serial half of a boundary-scan test master. A host loads a 32-bit word of TDO data and a 16-bit word of TMS data through a small write port, then issues a start with a bit count from 1 to 32. The engine generates that many TCK pulses. Each pulse takes two system clocks: one with TCK low and one with TCK high. TDO and TMS leave LSB first and change only when TCK falls. TDI is sampled when TCK rises.

Each sampled TDI bit lands in a receive register at the position of its bit index. The same bit can also be folded into a 32-bit signature LFSR. The host must seed the LFSR and give it a tap mask before use. A masked compare against expected data drives a sticky pass flag. That flag comes out of reset at fail and can only be set back to pass by the host.

When no bits are being shifted, TDO follows a programmable idle policy. It can hold the last bit, drive a configured level, or release the line. The host reads results back as 16-bit halves through a select port.

Top module: `jtag_shift_engine`

## Requirements
- R1: After reset TCK is low and `busy` is low. A start with `shift_len` from 1 to 32, while idle, raises `busy` and then produces exactly `shift_len` TCK pulses. Each pulse is one clock low followed by one clock high. TCK and `busy` fall together after the last pulse. A start with `shift_len` of 0 or above 32 is ignored.
- R2: TDO shifts out the 32-bit word written at address 0 (bits 15:0) and address 1 (bits 31:16), LSB first. The first bit is on TDO when `busy` rises. Each following bit appears at the falling edge of TCK, so TDO is stable across every rising edge.
- R3: TMS shifts out the 16-bit word at address 2, LSB first, with the same timing as TDO. TMS is 0 for bit positions 16 and above, and 0 while idle.
- R4: TDI is sampled at each rising edge of TCK. Bit k of the receive register holds the k-th sampled bit. All receive bits are cleared at start. `rd_sel` 0 reads bits 15:0 and `rd_sel` 1 reads bits 31:16.
- R5: The control word at address 11 sets the idle behaviour. Field [1:0] selects the mode: 00 holds the last shifted TDO bit (0 after reset), 01 and 10 drive the level of bit [2], and 11 drives `tdo_oe` low. `tdo_oe` is high during every shift.
- R6: Writes to addresses 9 and 10 load LFSR bits 15:0 and 31:16 directly. Addresses 7 and 8 hold the low and high halves of the tap mask P. When control bit [3] is 1, every sampled bit b updates the state s. First f = b XOR s[31], then s becomes {s[30:0],0} XOR (f ? P : 0). `rd_sel` 2 and 3 read the low and high halves of s.
- R7: With control bit [3] at 0, shifting leaves the LFSR unchanged.
- R8: Expected data sits at addresses 3 and 4 and the mask at addresses 5 and 6, where a mask bit of 1 means that bit is checked. `cmp_ok` is 0 after reset. A write to address 12 with data bit 0 set makes `cmp_ok` 1. When control bit [4] is 1, any checked sampled bit k that differs from expected bit k clears `cmp_ok`, and it stays 0 through later matching shifts.
- R9: Mismatches in unchecked bits, or in any bit while control bit [4] is 0, leave `cmp_ok` unchanged.
- R10: A start pulse while `busy` is high is ignored, and the current shift keeps its pulse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration/data port |
| cfg_addr | input | 4 | Write address |
| cfg_wdata | input | 16 | Write data |
| rd_sel | input | 2 | Read select: capture low/high, signature low/high |
| rd_data | output | 16 | Selected read half-word |
| start | input | 1 | Begin a shift of `shift_len` bits |
| shift_len | input | 6 | Number of bits to shift (1..32) |
| busy | output | 1 | High while shifting |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdo | output | 1 | Serial data to the scan chain |
| tdo_oe | output | 1 | TDO output enable |
| tdi | input | 1 | Serial data from the scan chain |
| cmp_ok | output | 1 | Sticky compare pass flag |

## Verification
The shift path is exercised with a full 32-bit word of mixed bit values and with a short 5-bit shift. The full word exposes bit-order and TMS fill errors. The short shift exposes pulse-count and partial capture errors. A second start inside a running shift and a zero-length start show whether the pulse count can be disturbed.

The signature is checked after one 32-bit TDI stream with feedback enabled, and again after a shift with feedback disabled. The first shows the tap and XOR placement; the second shows that the state is left alone. The compare flag is driven through four cases: a clean match, a checked mismatch, a later clean match that must not restore pass, and mismatches hidden by the mask or by a disabled compare. Together these separate stickiness from masking.

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
  parameter int DW = 32,
  parameter int MW = 16,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [MW-1:0] cfg_wdata,
  input  logic [1:0]    rd_sel,
  output logic [MW-1:0] rd_data,
  input  logic          start,
  input  logic [LW-1:0] shift_len,
  output logic          busy,
  output logic          tck,
  output logic          tms,
  output logic          tdo,
  output logic          tdo_oe,
  input  logic          tdi,
  output logic          cmp_ok
);
  localparam int HW = DW / 2;

  logic [DW-1:0] tdo_word, tdo_sr, exp_w, mask_w, poly, lfsr, rx;
  logic [MW-1:0] tms_word, tms_sr;
  logic [4:0]    ctrl;
  logic [LW-1:0] len_q, cnt;
  logic          ph, last_bit;

  wire go   = start && !busy && shift_len != '0 && shift_len <= LW'(DW);
  wire rise = busy && !ph;
  wire fall = busy && ph;
  wire [1:0] mode = ctrl[1:0];
  wire fb = tdi ^ lfsr[DW-1];
  wire [DW-1:0] lfsr_nx = {lfsr[DW-2:0], 1'b0} ^ (fb ? poly : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_word <= '0; tms_word <= '0; exp_w <= '0; mask_w <= '0;
      poly <= '0; ctrl <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0:  tdo_word[HW-1:0]  <= cfg_wdata;
        4'd1:  tdo_word[DW-1:HW] <= cfg_wdata;
        4'd2:  tms_word          <= cfg_wdata;
        4'd3:  exp_w[HW-1:0]     <= cfg_wdata;
        4'd4:  exp_w[DW-1:HW]    <= cfg_wdata;
        4'd5:  mask_w[HW-1:0]    <= cfg_wdata;
        4'd6:  mask_w[DW-1:HW]   <= cfg_wdata;
        4'd7:  poly[HW-1:0]      <= cfg_wdata;
        4'd8:  poly[DW-1:HW]     <= cfg_wdata;
        4'd11: ctrl              <= cfg_wdata[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tck <= 1'b0; ph <= 1'b0; cnt <= '0; len_q <= '0;
      tdo_sr <= '0; tms_sr <= '0; last_bit <= 1'b0;
    end else if (go) begin
      busy <= 1'b1; ph <= 1'b0; cnt <= '0; len_q <= shift_len;
      tdo_sr <= tdo_word; tms_sr <= tms_word;
    end else if (rise) begin
      tck <= 1'b1; ph <= 1'b1;
    end else if (fall) begin
      tck <= 1'b0; ph <= 1'b0;
      last_bit <= tdo_sr[0];
      tdo_sr <= tdo_sr >> 1;
      tms_sr <= tms_sr >> 1;
      if (cnt == len_q - 1'b1) busy <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx <= '0;
    else if (go) rx <= '0;
    else if (rise) rx[cnt[4:0]] <= tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= '0;
    else if (cfg_we && cfg_addr == 4'd9)  lfsr[HW-1:0]  <= cfg_wdata;
    else if (cfg_we && cfg_addr == 4'd10) lfsr[DW-1:HW] <= cfg_wdata;
    else if (rise && ctrl[3]) lfsr <= lfsr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_ok <= 1'b0;
    else if (cfg_we && cfg_addr == 4'd12 && cfg_wdata[0]) cmp_ok <= 1'b1;
    else if (rise && ctrl[4] && mask_w[cnt[4:0]] && (tdi != exp_w[cnt[4:0]]))
      cmp_ok <= 1'b0;
  end

  assign tms    = busy ? tms_sr[0] : 1'b0;
  assign tdo    = busy ? tdo_sr[0]
                : (mode == 2'b00) ? last_bit
                : (mode == 2'b11) ? 1'b0 : ctrl[2];
  assign tdo_oe = busy || mode != 2'b11;

  always_comb begin
    case (rd_sel)
      2'd0: rd_data = rx[HW-1:0];
      2'd1: rd_data = rx[DW-1:HW];
      2'd2: rd_data = lfsr[HW-1:0];
      default: rd_data = lfsr[DW-1:HW];
    endcase
  end
endmodule

// File: rtl/jtag_shift_engine_checker.sv
module jtag_shift_engine_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        tck,
  input logic        tdo,
  input logic        tdo_oe,
  input logic        cmp_ok,
  input logic        cfg_we,
  input logic [3:0]  cfg_addr,
  input logic [15:0] cfg_wdata
);
  p_idle_tck_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tck);
  p_end_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(tck));
  p_tdo_stable_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> $stable(tdo));
  p_oe_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tdo_oe);
  p_pass_by_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ok) |-> $past(cfg_we && cfg_addr == 4'd12 && cfg_wdata[0]));
endmodule

bind jtag_shift_engine jtag_shift_engine_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tck(tck), .tdo(tdo),
  .tdo_oe(tdo_oe), .cmp_ok(cmp_ok), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
);

// File: tb/jtag_shift_engine_bench.sv
module jtag_shift_engine_bench;
  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0, tdi = 0;
  logic [3:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0, rd_data;
  logic [1:0] rd_sel = 0;
  logic [5:0] shift_len = 0;
  logic busy, tck, tms, tdo, tdo_oe, cmp_ok;
  int checks = 0, errors = 0, tdi_idx = 0;
  logic [31:0] tdi_word = 0;
  logic [1:0] sbq[$];
  logic [31:0] m_lfsr, m_poly;
  logic m_cmp;

  always #10ns clk = ~clk;

  jtag_shift_engine u_jtag_shift_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .start(start), .shift_len(shift_len), .busy(busy), .tck(tck),
    .tms(tms), .tdo(tdo), .tdo_oe(tdo_oe), .tdi(tdi), .cmp_ok(cmp_ok));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge tck) begin
    logic [1:0] e;
    if (sbq.size() == 0) chk("R1 extra pulse", 1, 0);
    else begin
      e = sbq.pop_front();
      chk("R2 tdo bit", {31'b0, tdo}, {31'b0, e[0]});
      chk("R3 tms bit", {31'b0, tms}, {31'b0, e[1]});
    end
  end

  always @(negedge tck) begin
    tdi_idx++;
    if (tdi_idx < 32) tdi = tdi_word[tdi_idx];
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd32(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_sel = s; #1; v[15:0] = rd_data;
    rd_sel = s + 1; #1; v[31:16] = rd_data;
  endtask

  task automatic run(logic [31:0] dw, logic [15:0] tw, int len, logic [31:0] iw,
                     logic [4:0] ctl, logic [31:0] ex, logic [31:0] mk, bit restart);
    logic [31:0] rx, exp_rx;
    wr(4'd0, dw[15:0]); wr(4'd1, dw[31:16]); wr(4'd2, tw);
    for (int i = 0; i < len; i++) begin
      sbq.push_back({(i < 16) ? tw[i] : 1'b0, dw[i]});
      if (ctl[3]) begin
        logic f;
        f = iw[i] ^ m_lfsr[31];
        m_lfsr = {m_lfsr[30:0], 1'b0} ^ (f ? m_poly : 32'h0);
      end
      if (ctl[4] && mk[i] && iw[i] != ex[i]) m_cmp = 0;
    end
    tdi_word = iw; tdi_idx = 0; tdi = iw[0];
    @(negedge clk); start = 1; shift_len = 6'(len);
    @(negedge clk); start = 0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1; shift_len = 6'd32;
      @(negedge clk); start = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R1/R10 pulse count", sbq.size(), 0);
    sbq.delete();
    exp_rx = (len == 32) ? iw : iw & ((32'h1 << len) - 1);
    rd32(2'd0, rx);
    chk("R4 capture", rx, exp_rx);
  endtask

  initial begin
    #(20ns * 150000);
    chk("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_lfsr = 0; m_poly = 0; m_cmp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset tck", {31'b0, tck}, 0);
    chk("R1 reset busy", {31'b0, busy}, 0);
    chk("R8 reset cmp", {31'b0, cmp_ok}, 0);
    chk("R5 reset oe", {31'b0, tdo_oe}, 1);
    chk("R5 reset hold", {31'b0, tdo}, 0);

    run(32'hA5C3_1E7F, 16'h8421, 32, 32'h1234_5678, 5'd0, 0, 0, 0);
    chk("R5 hold last", {31'b0, tdo}, 1);
    wr(4'd11, 16'h0001); @(negedge clk);
    chk("R5 default 0", {31'b0, tdo}, 0);
    wr(4'd11, 16'h0006); @(negedge clk);
    chk("R5 default 1", {31'b0, tdo}, 1);
    wr(4'd11, 16'h0003); @(negedge clk);
    chk("R5 release", {31'b0, tdo_oe}, 0);
    wr(4'd11, 16'h0000);

    run(32'h0000_0016, 16'h0009, 5, 32'hFFFF_FFF5, 5'd0, 0, 0, 1);
    chk("R5 hold after 5", {31'b0, tdo}, 1);
    @(negedge clk); start = 1; shift_len = 0;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    chk("R1 zero len ignored", {31'b0, busy}, 0);
    chk("R1 zero len tck", {31'b0, tck}, 0);

    m_poly = 32'h04C1_1DB7; m_lfsr = 32'hFFFF_FFFF;
    wr(4'd7, 16'h1DB7); wr(4'd8, 16'h04C1);
    wr(4'd9, 16'hFFFF); wr(4'd10, 16'hFFFF);
    wr(4'd11, 16'h0008);
    run(32'h0, 16'h0, 32, 32'hDEAD_BEEF, 5'h08, 0, 0, 0);
    rd32(2'd2, v);
    chk("R6 signature", v, m_lfsr);
    wr(4'd11, 16'h0000);
    run(32'h0, 16'h0, 32, 32'h5555_0F0F, 5'h00, 0, 0, 0);
    rd32(2'd2, v);
    chk("R7 signature held", v, m_lfsr);

    wr(4'd3, 16'hFFFF); wr(4'd4, 16'h0000);
    wr(4'd5, 16'hFFFF); wr(4'd6, 16'hFFFF);
    wr(4'd11, 16'h0010);
    wr(4'd12, 16'h0001); m_cmp = 1;
    chk("R8 clear sets pass", {31'b0, cmp_ok}, 1);
    run(32'h0, 16'h0, 32, 32'h0000_FFFF, 5'h10, 32'h0000_FFFF, 32'hFFFF_FFFF, 0);
    chk("R8 match pass", {31'b0, cmp_ok}, {31'b0, m_cmp});
    run(32'h0, 16'h0, 32, 32'h0000_FFF7, 5'h10, 32'h0000_FFFF, 32'hFFFF_FFFF, 0);
    chk("R8 mismatch fail", {31'b0, cmp_ok}, 0);
    run(32'h0, 16'h0, 32, 32'h0000_FFFF, 5'h10, 32'h0000_FFFF, 32'hFFFF_FFFF, 0);
    chk("R8 sticky fail", {31'b0, cmp_ok}, 0);
    wr(4'd12, 16'h0001); m_cmp = 1;
    wr(4'd5, 16'hFFF7);
    run(32'h0, 16'h0, 32, 32'h0000_FFF7, 5'h10, 32'h0000_FFFF, 32'hFFFF_FFF7, 0);
    chk("R9 masked mismatch", {31'b0, cmp_ok}, 1);
    wr(4'd11, 16'h0000);
    run(32'h0, 16'h0, 32, 32'hFFFF_0000, 5'h00, 32'h0000_FFFF, 32'hFFFF_FFF7, 0);
    chk("R9 compare off", {31'b0, cmp_ok}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule